// File: doc/BRIEF.md
# Misaligned Load/Store Bus Splitter

This block sits between a load/store unit and a 64-bit memory bus with per-byte enables. It takes one request at a time: a byte address, an operand size (8, 16, 32 or 64 bits), a direction flag and write data. It decides whether the operand fits in a single bus transfer or must be moved as two. It then issues the bus transfers with beat-aligned addresses and byte-lane enables. Write bytes are rotated into their lanes. Read bytes from one or both transfers are gathered and shifted back into a single little-endian result, which appears with a one-cycle completion pulse.

The split rule depends on the operand size, not on the bus width. 16-bit and 32-bit operands are split only at 4-byte group boundaries, so a 32-bit operand at offset 2 takes two transfers even though both halves lie in the same 8-byte beat. A 64-bit operand is split only when its address is not a multiple of 8. Single bytes never split. A 16-bit operand at an odd address whose two bytes stay inside one 4-byte group finishes in one transfer.

Top module: `misalign_splitter`

## Requirements
- R1: A byte operand (size code 0) always completes in one bus transfer that enables exactly the lane equal to address bits [2:0]. Write data above the low byte has no effect on memory.
- R2: A 16-bit (size code 1) or 32-bit (size code 2) operand whose bytes all lie in one 4-byte-aligned group uses one bus transfer. This includes a 16-bit operand at offset 1 (enable mask 06h) and one at offset 6.
- R3: A 16-bit or 32-bit operand that crosses a 4-byte group boundary uses two transfers. The first enables the lower-addressed bytes and the second the higher-addressed bytes. At offset 2, a 32-bit operand uses beat 0 with masks 0Ch then 30h. At offset 5, it uses beat 0 with mask E0h, then beat +8 with mask 01h.
- R4: A 64-bit operand (size code 3) uses one transfer with mask FFh when address bits [2:0] are zero. Otherwise it uses two transfers. The first has mask FFh shifted left by the offset at the current beat. The second covers the remaining low lanes at the next beat, 8 bytes higher.
- R5: Every bus transfer carries an address whose bits [2:0] are zero and a non-zero byte-enable mask.
- R6: On a write, operand byte i is placed on lane (address + i) mod 8 of the transfer that covers address + i. Memory outside the operand's bytes is unchanged.
- R7: On a read, the result holds the byte at the operand address in bits 7:0 and higher addresses in higher bytes. Example: memory holds 0B,23,A4,1F,36,06,FE,7A at addresses 6h to Dh. Then a 64-bit read at 6h returns 7AFE06361FA4230Bh, a 16-bit read at 6h returns 230Bh, a 32-bit read at Ah returns 7AFE0636h, a 16-bit read at Bh returns FE06h and a byte read at 9h returns 1Fh.
- R8: The request side is ready only while no transfer is in progress. A bus transfer holds its valid, address and mask unchanged until acknowledged, and the next transfer starts only after that acknowledge.
- R9: Completion is a single-cycle pulse on the cycle after the final acknowledge. The read result is zero-extended above the operand size and is zero for writes.
- R10: A synchronous active-high reset, even in mid-transfer, returns the block to idle: ready high, no bus transfer, no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 64-bit |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 8*BUS_BYTES | Store data, operand in the low bytes |
| bus_valid | output | 1 | Bus transfer requested |
| bus_addr | output | ADDR_W | Beat-aligned transfer address |
| bus_be | output | BUS_BYTES | Byte-lane enables |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 8*BUS_BYTES | Lane-steered store data |
| bus_ack | input | 1 | Transfer accepted/completed this cycle |
| bus_rdata | input | 8*BUS_BYTES | Load data, valid with bus_ack |
| done | output | 1 | Operation complete pulse |
| rdata | output | 8*BUS_BYTES | Assembled load result |

## Verification
On every cycle, the assertions check that bus addresses are beat-aligned, that masks are non-empty, and that a waiting transfer holds steady until acknowledged. They also check that the block never looks ready during a transfer, that completion is one cycle wide, and what the first mask looks like for each accepted byte, 16-bit and 64-bit request. The number of transfers, the mask and beat of the second half, the byte values placed in memory and the merged load results can only be seen end to end. The directed scenarios show these against a byte-array memory model, including acknowledge stalls and a reset in mid-transfer.

// File: rtl/misalign_pkg.sv
package misalign_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_QWORD = 2'd3
   } op_size_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2,
      ST_DONE   = 2'd3
   } xfer_state_e;
endpackage

// File: rtl/split_planner.sv
module split_planner
   import misalign_pkg::*;
#(
   parameter int BUS_BYTES   = 8,
   parameter int GROUP_BYTES = 4
) (
   input  logic [$clog2(BUS_BYTES)-1:0] off,
   input  op_size_e                     size,
   output logic                         split,
   output logic                         hi_next_beat,
   output logic [BUS_BYTES-1:0]         mask_lo,
   output logic [BUS_BYTES-1:0]         mask_hi
);
   localparam int OFF_W = $clog2(BUS_BYTES);
   localparam int LANES = 2 * BUS_BYTES;
   localparam int CW    = OFF_W + 2;
   localparam logic [CW-1:0] BUSB     = CW'(BUS_BYTES);
   localparam logic [CW-1:0] GRP      = CW'(GROUP_BYTES);
   localparam logic [CW-1:0] GRP_MASK = ~CW'(GROUP_BYTES - 1);

   logic [CW-1:0]    nbytes;
   logic [CW-1:0]    grp_bnd;
   logic [CW-1:0]    bnd;
   logic [LANES-1:0] full;
   logic [LANES-1:0] below;
   logic [LANES-1:0] hi_lanes;

   always_comb nbytes = CW'(1) << size;
   always_comb full   = ((LANES'(1) << nbytes) - LANES'(1)) << off;

   generate
      if (GROUP_BYTES == BUS_BYTES) begin : g_grp_is_beat
         always_comb grp_bnd = BUSB;
      end else begin : g_grp_sub_beat
         always_comb grp_bnd = (CW'(off) & GRP_MASK) + GRP;
      end
   endgenerate

   always_comb begin
      bnd          = (size == SZ_QWORD) ? BUSB : grp_bnd;
      split        = (CW'(off) + nbytes) > bnd;
      below        = (LANES'(1) << bnd) - LANES'(1);
      hi_lanes     = full & ~below;
      hi_next_beat = (bnd == BUSB);
      mask_lo      = full[BUS_BYTES-1:0] & below[BUS_BYTES-1:0];
      mask_hi      = hi_next_beat ? hi_lanes[LANES-1:BUS_BYTES]
                                  : hi_lanes[BUS_BYTES-1:0];
   end
endmodule

// File: rtl/lane_rotator.sv
module lane_rotator
   import misalign_pkg::*;
#(
   parameter int BUS_BYTES = 8
) (
   input  logic [$clog2(BUS_BYTES)-1:0] off,
   input  op_size_e                     size,
   input  logic [8*BUS_BYTES-1:0]       wdata,
   input  logic [16*BUS_BYTES-1:0]      rd_wide,
   output logic [16*BUS_BYTES-1:0]      wr_wide,
   output logic [8*BUS_BYTES-1:0]       rd_val
);
   localparam int OFF_W = $clog2(BUS_BYTES);
   localparam int DW    = 8 * BUS_BYTES;
   localparam int IW    = OFF_W + 1;

   logic [OFF_W+1:0] nbytes;

   always_comb nbytes  = (OFF_W + 2)'(1) << size;
   always_comb wr_wide = {{DW{1'b0}}, wdata} << {off, 3'b000};

   generate
      for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
         logic [IW-1:0] src;
         always_comb begin
            src = IW'(off) + IW'(i);
            rd_val[8*i +: 8] = ((OFF_W + 2)'(i) < nbytes)
                               ? rd_wide[{src, 3'b000} +: 8] : 8'h00;
         end
      end
   endgenerate
endmodule

// File: rtl/misalign_splitter.sv
module misalign_splitter
   import misalign_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int BUS_BYTES   = 8,
   parameter int GROUP_BYTES = 4
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [1:0]             req_size,
   input  logic                   req_write,
   input  logic [8*BUS_BYTES-1:0] req_wdata,
   output logic                   bus_valid,
   output logic [ADDR_W-1:0]      bus_addr,
   output logic [BUS_BYTES-1:0]   bus_be,
   output logic                   bus_write,
   output logic [8*BUS_BYTES-1:0] bus_wdata,
   input  logic                   bus_ack,
   input  logic [8*BUS_BYTES-1:0] bus_rdata,
   output logic                   done,
   output logic [8*BUS_BYTES-1:0] rdata
);
   localparam int OFF_W = $clog2(BUS_BYTES);
   localparam int DW    = 8 * BUS_BYTES;

   generate
      if (BUS_BYTES != 8) begin : g_bad_bus
         $error("misalign_splitter: BUS_BYTES must be 8");
      end
      if ((GROUP_BYTES < 2) || (GROUP_BYTES > BUS_BYTES) ||
          ((GROUP_BYTES & (GROUP_BYTES - 1)) != 0)) begin : g_bad_grp
         $error("misalign_splitter: GROUP_BYTES must be a power of two in 2..BUS_BYTES");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("misalign_splitter: ADDR_W too small");
      end
   endgenerate

   xfer_state_e       state_q;
   logic [ADDR_W-1:0] addr_q;
   op_size_e          size_q;
   logic              wr_q;
   logic [DW-1:0]     wdata_q;
   logic [2*DW-1:0]   gather_q;

   logic              split;
   logic              hi_next_beat;
   logic [BUS_BYTES-1:0] mask_lo;
   logic [BUS_BYTES-1:0] mask_hi;
   logic [2*DW-1:0]   wr_wide;
   logic [DW-1:0]     rd_val;
   logic              second;
   logic              beat_up;
   logic              accept;
   logic              beat_done;

   split_planner #(.BUS_BYTES(BUS_BYTES), .GROUP_BYTES(GROUP_BYTES)) u_plan (
      .off          (addr_q[OFF_W-1:0]),
      .size         (size_q),
      .split        (split),
      .hi_next_beat (hi_next_beat),
      .mask_lo      (mask_lo),
      .mask_hi      (mask_hi)
   );

   lane_rotator #(.BUS_BYTES(BUS_BYTES)) u_rot (
      .off     (addr_q[OFF_W-1:0]),
      .size    (size_q),
      .wdata   (wdata_q),
      .rd_wide (gather_q),
      .wr_wide (wr_wide),
      .rd_val  (rd_val)
   );

   always_comb begin
      req_ready = (state_q == ST_IDLE);
      accept    = req_ready && req_valid;
      bus_valid = (state_q == ST_FIRST) || (state_q == ST_SECOND);
      second    = (state_q == ST_SECOND);
      beat_up   = second && hi_next_beat;
      beat_done = bus_valid && bus_ack;
      bus_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                  + (beat_up ? ADDR_W'(BUS_BYTES) : ADDR_W'(0));
      bus_be    = !bus_valid ? '0 : (second ? mask_hi : mask_lo);
      bus_write = wr_q;
      bus_wdata = beat_up ? wr_wide[2*DW-1:DW] : wr_wide[DW-1:0];
      done      = (state_q == ST_DONE);
      rdata     = (done && !wr_q) ? rd_val : '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         size_q  <= SZ_BYTE;
         wr_q    <= 1'b0;
         wdata_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_FIRST;
               addr_q  <= req_addr;
               size_q  <= op_size_e'(req_size);
               wr_q    <= req_write;
               wdata_q <= req_wdata;
            end
            ST_FIRST:  if (bus_ack) state_q <= split ? ST_SECOND : ST_DONE;
            ST_SECOND: if (bus_ack) state_q <= ST_DONE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < BUS_BYTES; i++) begin : g_gather
         always_ff @(posedge clk) begin
            if (rst || accept) begin
               gather_q[8*i +: 8]      <= 8'h00;
               gather_q[DW + 8*i +: 8] <= 8'h00;
            end else if (beat_done && bus_be[i]) begin
               if (beat_up) gather_q[DW + 8*i +: 8] <= bus_rdata[8*i +: 8];
               else         gather_q[8*i +: 8]      <= bus_rdata[8*i +: 8];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/misalign_splitter_chk.sv
module misalign_splitter_chk #(
   parameter int BUS_BYTES = 8
) (
   input logic                         clk,
   input logic                         rst,
   input logic                         req_valid,
   input logic                         req_ready,
   input logic [1:0]                   req_size,
   input logic [$clog2(BUS_BYTES)-1:0] req_off,
   input logic                         bus_valid,
   input logic [$clog2(BUS_BYTES)-1:0] bus_off,
   input logic [BUS_BYTES-1:0]         bus_be,
   input logic                         bus_ack,
   input logic                         done
);
   logic take;
   always_comb take = req_valid && req_ready;

   assert_bus_aligned_R5: assert property (@(posedge clk) disable iff (rst)
      bus_valid |-> (bus_off == '0));

   assert_mask_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
      bus_valid |-> (bus_be != '0));

   assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_off) && $stable(bus_be)));

   assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (!bus_valid && !done));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_byte_one_lane_R1: assert property (@(posedge clk) disable iff (rst)
      (take && req_size == 2'd0) |=>
         (bus_valid && $countones(bus_be) == 1 && bus_be[$past(req_off)]));

   assert_word_in_group_R2: assert property (@(posedge clk) disable iff (rst)
      (take && req_size == 2'd1 && req_off[1:0] != 2'd3) |=>
         (bus_valid && $countones(bus_be) == 2));

   assert_word_cross_first_R3: assert property (@(posedge clk) disable iff (rst)
      (take && req_size == 2'd1 && req_off[1:0] == 2'd3) |=>
         (bus_valid && $countones(bus_be) == 1));

   assert_qword_first_mask_R4: assert property (@(posedge clk) disable iff (rst)
      (take && req_size == 2'd3) |=>
         (bus_valid && bus_be == (BUS_BYTES'('1) << $past(req_off))));
endmodule

bind misalign_splitter misalign_splitter_chk #(.BUS_BYTES(BUS_BYTES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_size  (req_size),
   .req_off   (req_addr[OFF_W-1:0]),
   .bus_valid (bus_valid),
   .bus_off   (bus_addr[OFF_W-1:0]),
   .bus_be    (bus_be),
   .bus_ack   (bus_ack),
   .done      (done)
);

// File: tb/tb_misalign_splitter.sv
`timescale 1ns/1ps
module tb_misalign_splitter;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [63:0] req_wdata = '0;
   logic        bus_valid;
   logic [31:0] bus_addr;
   logic [7:0]  bus_be;
   logic        bus_write;
   logic [63:0] bus_wdata;
   logic        bus_ack = 1'b0;
   logic [63:0] bus_rdata = '0;
   logic        done;
   logic [63:0] rdata;

   int checks = 0;
   int errors = 0;
   logic [7:0] mem [0:31];

   always #2.5 clk = ~clk;

   misalign_splitter dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
      .req_wdata(req_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_write(bus_write), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .rdata(rdata)
   );

   task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [255:0] mem_image();
      logic [255:0] v = '0;
      for (int i = 0; i < 32; i++) v[8*i +: 8] = mem[i];
      return v;
   endfunction

   function automatic int exp_cycles(input int a, input int sz);
      int n = 1 << sz;
      if (sz == 0) return 1;
      if (sz == 3) return (a % 8 != 0) ? 2 : 1;
      return ((a % 4) + n > 4) ? 2 : 1;
   endfunction

   // Drives one request and plays memory for its bus transfers.
   task automatic run_op(input int a, input int sz, input logic wr, input logic [63:0] wd,
                         input int stall, output int ncyc, output logic [31:0] a1,
                         output logic [7:0] be1, output logic [31:0] a2, output logic [7:0] be2,
                         output logic [63:0] res, output int ndone, output int busy_ready);
      int left;
      ncyc = 0; ndone = 0; busy_ready = 0; a1 = '0; a2 = '0; be1 = '0; be2 = '0; res = '1;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'(a); req_size = 2'(sz);
      req_write = wr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      left = stall;
      for (int guard = 0; guard < 64; guard++) begin
         bus_ack = 1'b0;
         if (done) begin
            ndone++;
            res = rdata;
            @(negedge clk);
            if (done) ndone++;
            break;
         end
         if (bus_valid) begin
            if (req_ready) busy_ready++;
            if (left > 0) begin
               left--;
            end else begin
               ncyc++;
               if (ncyc == 1) begin a1 = bus_addr; be1 = bus_be; end
               else begin a2 = bus_addr; be2 = bus_be; end
               for (int i = 0; i < 8; i++) begin
                  bus_rdata[8*i +: 8] = mem[int'(bus_addr[4:0]) + i];
                  if (bus_write && bus_be[i]) mem[int'(bus_addr[4:0]) + i] = bus_wdata[8*i +: 8];
               end
               bus_ack = 1'b1;
               left = stall;
            end
         end
         @(negedge clk);
      end
      bus_ack = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R10 ready after reset", 256'(req_ready), 256'(1));
      chk("R10 no bus after reset", 256'(bus_valid), 256'(0));
      chk("R10 no done after reset", 256'(done), 256'(0));
   endtask

   task automatic t_example_reads();
      logic [31:0] a1, a2; logic [7:0] b1, b2; logic [63:0] r; int n, d, br;
      logic [7:0] init [0:7] = '{8'h0B, 8'h23, 8'hA4, 8'h1F, 8'h36, 8'h06, 8'hFE, 8'h7A};
      for (int i = 0; i < 8; i++) mem[6 + i] = init[i];
      run_op(6, 3, 0, '0, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R7 qword at 6h", 256'(r), 256'(64'h7AFE06361FA4230B));
      chk("R4 qword at 6h cycles", 256'(n), 256'(exp_cycles(6, 3)));
      run_op(6, 1, 0, '0, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R7 word at 6h", 256'(r), 256'(64'h230B));
      chk("R2 word at 6h cycles", 256'(n), 256'(1));
      run_op(10, 2, 0, '0, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R7 dword at Ah", 256'(r), 256'(64'h7AFE0636));
      chk("R3 dword at Ah cycles", 256'(n), 256'(2));
      run_op(11, 1, 0, '0, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R7 word at Bh", 256'(r), 256'(64'hFE06));
      chk("R3 word at Bh cycles", 256'(n), 256'(2));
      run_op(9, 0, 0, '0, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R7 R9 byte at 9h zero-extended", 256'(r), 256'(64'h1F));
      chk("R1 byte cycles", 256'(n), 256'(1));
      chk("R1 byte lane", 256'(b1), 256'(8'h02));
   endtask

   task automatic t_in_group();
      logic [31:0] a1, a2; logic [7:0] b1, b2; logic [63:0] r; int n, d, br;
      run_op(9, 1, 0, '0, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R2 odd word cycles", 256'(n), 256'(1));
      chk("R2 odd word mask", 256'(b1), 256'(8'h06));
      chk("R5 R2 odd word addr", 256'(a1), 256'(32'h8));
      chk("R7 odd word value", 256'(r), 256'(64'h361F));
   endtask

   task automatic t_cross_group();
      logic [31:0] a1, a2; logic [7:0] b1, b2; logic [63:0] r; int n, d, br;
      run_op(2, 2, 0, '0, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R3 dword@2 cycles", 256'(n), 256'(2));
      chk("R3 dword@2 first", 256'({a1, b1}), 256'({32'h0, 8'h0C}));
      chk("R3 dword@2 second", 256'({a2, b2}), 256'({32'h0, 8'h30}));
      run_op(5, 2, 0, '0, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R3 dword@5 first", 256'({a1, b1}), 256'({32'h0, 8'hE0}));
      chk("R3 dword@5 second", 256'({a2, b2}), 256'({32'h8, 8'h01}));
      chk("R7 dword@5 value", 256'(r), 256'({32'h0, mem[8], mem[7], mem[6], mem[5]}));
   endtask

   task automatic t_qword();
      logic [31:0] a1, a2; logic [7:0] b1, b2; logic [63:0] r; int n, d, br;
      for (int i = 16; i < 32; i++) mem[i] = 8'(8'hC0 + i);
      run_op(16, 3, 0, '0, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R4 aligned qword cycles", 256'(n), 256'(1));
      chk("R4 aligned qword mask", 256'(b1), 256'(8'hFF));
      chk("R7 aligned qword value", 256'(r), 256'(64'hD7D6D5D4D3D2D1D0));
      run_op(19, 3, 0, '0, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R4 qword@13h first", 256'({a1, b1}), 256'({32'h10, 8'hF8}));
      chk("R4 qword@13h second", 256'({a2, b2}), 256'({32'h18, 8'h07}));
   endtask

   task automatic t_writes();
      logic [31:0] a1, a2; logic [7:0] b1, b2; logic [63:0] r; int n, d, br;
      logic [255:0] exp_img;
      exp_img = mem_image();
      for (int i = 0; i < 8; i++) exp_img[8*(19 + i) +: 8] = 8'(8'h88 - 8'h11 * i);
      run_op(19, 3, 1, 64'h1122334455667788, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R6 qword write memory", mem_image(), exp_img);
      chk("R9 write result zero", 256'(r), 256'(0));
      exp_img[8*23 +: 8] = 8'hEF; exp_img[8*24 +: 8] = 8'hBE;
      run_op(23, 1, 1, 64'hBEEF, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R6 split word write memory", mem_image(), exp_img);
      chk("R3 split word lanes", 256'({a1, b1, a2, b2}), 256'({32'h10, 8'h80, 32'h18, 8'h01}));
      run_op(19, 3, 0, '0, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R7 readback merged", 256'(r), 256'(64'h1122BEEF55667788));
      exp_img[8*28 +: 8] = 8'h5A;
      run_op(28, 0, 1, 64'hFFFFFFFFFFFFFF5A, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R1 byte write ignores upper data", mem_image(), exp_img);
   endtask

   task automatic t_stalls();
      logic [31:0] a1, a2; logic [7:0] b1, b2; logic [63:0] r; int n, d, br;
      run_op(10, 2, 0, '0, 3, n, a1, b1, a2, b2, r, d, br);
      chk("R8 stalled read value", 256'(r), 256'(64'h7AFE0636));
      chk("R8 not ready while busy", 256'(br), 256'(0));
      chk("R9 single done pulse", 256'(d), 256'(1));
   endtask

   task automatic t_reset_midflight();
      logic [31:0] a1, a2; logic [7:0] b1, b2; logic [63:0] r; int n, d, br;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'd5; req_size = 2'd2; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 transfer started", 256'(bus_valid), 256'(1));
      rst = 1'b1;
      @(negedge clk);
      chk("R10 idle after mid reset", 256'({req_ready, bus_valid, done}), 256'(3'b100));
      rst = 1'b0;
      run_op(6, 3, 0, '0, 0, n, a1, b1, a2, b2, r, d, br);
      chk("R10 works after reset", 256'(r), 256'(64'h7AFE06361FA4230B));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) mem[i] = 8'(8'h40 + i);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_example_reads();
      t_in_group();
      t_cross_group();
      t_qword();
      t_writes();
      t_stalls();
      t_reset_midflight();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule